// File: doc/BRIEF.md
# Isochronous Receive Gate with Block Partitioning

This block sits between the link-layer receiver and the general receive FIFO. Every incoming packet arrives as a stream of beats. Each beat carries start and end markers, a valid strobe, an isochronous flag and, on the last beat, a bad-packet flag. The block decides from the header beat whether the packet goes into the FIFO. It then writes the accepted beats at consecutive FIFO addresses that it tracks itself, and it tells the host when a packet is complete.

Two channel filters, each with its own enable, decide which isochronous packets are kept. Packets that are not isochronous always pass. In trigger mode the block reports each filled block of a programmed number of words as soon as it is written, so the host can start draining a long packet early. A flush mode removes bad packets from the FIFO by rewinding the write address to the start of the packet. This includes packets cut short because the FIFO filled up. Flush mode also turns trigger mode off.

Top module: `rx_iso_gate`

## Requirements
- R1: An isochronous packet whose channel matches `p1_chan` is accepted while `p1_en` is high. The channel is bits [13:8] of the header beat, which is the beat with `in_sop`.
- R2: An isochronous packet whose channel matches `p2_chan` is accepted while `p2_en` is high, independently of port 1.
- R3: An isochronous packet that no enabled port matches causes no FIFO write and no interrupt. A packet with `in_iso` low is always accepted.
- R4: Each accepted beat produces one `fifo_we` pulse in the cycle after the beat, carrying the beat data. Addresses start at 0 after reset, step by one and wrap modulo 2^AW.
- R5: With trigger mode active, `blk_ready` pulses in the cycle after every `trig_size`-th word of a packet is written.
- R6: A final block shorter than `trig_size` is signalled by `blk_ready` in the cycle after the end beat. A packet whose length is an exact multiple of `trig_size` gives no extra pulse.
- R7: A `trig_size` of zero behaves as if trigger mode were off, so `blk_ready` never pulses.
- R8: With `flush_bad` high, a packet that ends with `in_bad` is discarded. Its end beat is not written. One cycle after the end beat, `fifo_rewind` pulses with `fifo_rewind_addr` equal to the packet's first address, and the next packet starts at that address. No `rx_int` is raised for it.
- R9: A beat that arrives while `fifo_full` is high is not written, and neither is any later beat of that packet. Such a truncated packet counts as bad, so R8 applies to it when flushing is on.
- R10: While `flush_bad` is high, `blk_ready` never pulses, whatever `trig_en` is.
- R11: `rx_int` pulses one cycle after the end beat of every accepted packet that is not flushed. This includes a bad or truncated packet while `flush_bad` is low.
- R12: During and right after reset, all outputs are low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p1_en | input | 1 | Channel filter 1 enable |
| p1_chan | input | 6 | Channel filter 1 value |
| p2_en | input | 1 | Channel filter 2 enable |
| p2_chan | input | 6 | Channel filter 2 value |
| trig_en | input | 1 | Trigger partitioning enable |
| trig_size | input | TSW | Words per trigger block |
| flush_bad | input | 1 | Discard bad packets; overrides trigger mode |
| in_valid | input | 1 | Beat valid |
| in_sop | input | 1 | First beat of packet (header) |
| in_eop | input | 1 | Last beat of packet |
| in_iso | input | 1 | Packet is isochronous (sampled on header beat) |
| in_bad | input | 1 | Packet bad (sampled on end beat) |
| in_data | input | DW | Beat data |
| fifo_full | input | 1 | FIFO cannot take a word |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_waddr | output | AW | FIFO write address |
| fifo_wdata | output | DW | FIFO write data |
| fifo_rewind | output | 1 | Pulse: restore write address |
| fifo_rewind_addr | output | AW | Address the FIFO write pointer returns to |
| blk_ready | output | 1 | Pulse: a trigger block is complete |
| rx_int | output | 1 | Pulse: a packet was received |

## Verification
Every result comes from a single register stage, so each write, block pulse, rewind and interrupt is due exactly one cycle after the beat that causes it. The bench drives a beat just after a rising edge and samples the outputs one nanosecond after the next edge. It then attributes whatever it sees to that beat's index in the packet. This makes checks such as "block pulse on beats 3, 7 and 9" exact bit masks, not just counts. One idle cycle after each packet confirms that nothing shows up late.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam int CHAN_W   = 6;
  localparam int CHAN_LSB = 8;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_TAKE,
    PS_SKIP
  } pkt_state_e;
endpackage

// File: rtl/rxg_chan_match.sv
module rxg_chan_match
  import rxg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NPORT = 2
) (
  input  logic [DW-1:0]           hdr,
  input  logic                    iso,
  input  logic [NPORT-1:0]        port_en,
  input  logic [NPORT*CHAN_W-1:0] port_chan,
  output logic                    accept
);
  logic [CHAN_W-1:0] hdr_chan;
  logic [NPORT-1:0]  hit;

  assign hdr_chan = hdr[CHAN_LSB +: CHAN_W];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign hit[g] = port_en[g] && (hdr_chan == port_chan[g*CHAN_W +: CHAN_W]);
  end

  // non-isochronous traffic is never filtered
  assign accept = !iso || (|hit);
endmodule

// File: rtl/rxg_wr_track.sv
module rxg_wr_track
  import rxg_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic          in_bad,
  input  logic [DW-1:0] in_data,
  input  logic          accept_now,
  input  logic          fifo_full,
  input  logic          flush_bad,
  output logic          beat_wr,
  output logic          pkt_end,
  output logic          end_ok,
  output logic          fifo_we,
  output logic [AW-1:0] fifo_waddr,
  output logic [DW-1:0] fifo_wdata,
  output logic          fifo_rewind,
  output logic [AW-1:0] fifo_rewind_addr,
  output logic          rx_int
);
  pkt_state_e    st_q;
  logic          trunc_q;
  logic [AW-1:0] wptr_q;
  logic [AW-1:0] start_q;

  logic          sop_v;
  logic          taking;
  logic          trunc_prev;
  logic          trunc_now;
  logic          bad_now;
  logic          flush_now;
  logic          wr_raw;
  logic [AW-1:0] start_now;

  always_comb begin
    sop_v      = in_valid && in_sop;
    trunc_prev = sop_v ? 1'b0 : trunc_q;
    taking     = in_valid && (in_sop ? accept_now : (st_q == PS_TAKE));
    trunc_now  = trunc_prev || (taking && fifo_full);
    wr_raw     = taking && !fifo_full && !trunc_prev;
    pkt_end    = taking && in_eop;
    bad_now    = in_bad || trunc_now;
    flush_now  = pkt_end && flush_bad && bad_now;
    end_ok     = pkt_end && !flush_now;
    // the end beat of a discarded packet is never written
    beat_wr    = wr_raw && !flush_now;
    start_now  = sop_v ? wptr_q : start_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q             <= PS_IDLE;
      trunc_q          <= 1'b0;
      wptr_q           <= '0;
      start_q          <= '0;
      fifo_we          <= 1'b0;
      fifo_waddr       <= '0;
      fifo_wdata       <= '0;
      fifo_rewind      <= 1'b0;
      fifo_rewind_addr <= '0;
      rx_int           <= 1'b0;
    end else begin
      fifo_we     <= beat_wr;
      fifo_rewind <= flush_now;
      rx_int      <= end_ok;
      if (beat_wr) begin
        fifo_waddr <= wptr_q;
        fifo_wdata <= in_data;
      end
      if (flush_now) begin
        fifo_rewind_addr <= start_now;
        wptr_q           <= start_now;
      end else if (beat_wr) begin
        wptr_q <= wptr_q + 1'b1;
      end
      if (sop_v) start_q <= wptr_q;
      if (in_valid) begin
        trunc_q <= in_eop ? 1'b0 : trunc_now;
        if (in_eop)      st_q <= PS_IDLE;
        else if (in_sop) st_q <= accept_now ? PS_TAKE : PS_SKIP;
      end
    end
  end
endmodule

// File: rtl/rxg_block_split.sv
module rxg_block_split #(
  parameter int TSW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trig_en,
  input  logic [TSW-1:0] trig_size,
  input  logic           flush_bad,
  input  logic           beat_wr,
  input  logic           pkt_end,
  input  logic           end_ok,
  output logic           blk_ready
);
  localparam int CW = TSW + 1;

  logic          active;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign active  = trig_en && !flush_bad && (trig_size != '0);
  assign cnt_inc = cnt_q + CW'(beat_wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      blk_ready <= 1'b0;
    end else if (!active) begin
      cnt_q     <= '0;
      blk_ready <= 1'b0;
    end else if (pkt_end) begin
      // short tail block reported with the end of packet
      cnt_q     <= '0;
      blk_ready <= end_ok && (cnt_inc != '0);
    end else if (beat_wr && (cnt_inc == CW'(trig_size))) begin
      cnt_q     <= '0;
      blk_ready <= 1'b1;
    end else begin
      cnt_q     <= cnt_inc;
      blk_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_iso_gate.sv
module rx_iso_gate
  import rxg_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 9,
  parameter int TSW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p1_en,
  input  logic [CHAN_W-1:0] p1_chan,
  input  logic              p2_en,
  input  logic [CHAN_W-1:0] p2_chan,
  input  logic              trig_en,
  input  logic [TSW-1:0]    trig_size,
  input  logic              flush_bad,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_iso,
  input  logic              in_bad,
  input  logic [DW-1:0]     in_data,
  input  logic              fifo_full,
  output logic              fifo_we,
  output logic [AW-1:0]     fifo_waddr,
  output logic [DW-1:0]     fifo_wdata,
  output logic              fifo_rewind,
  output logic [AW-1:0]     fifo_rewind_addr,
  output logic              blk_ready,
  output logic              rx_int
);
  localparam int NPORT = 2;

  logic accept_now;
  logic beat_wr;
  logic pkt_end;
  logic end_ok;

  rxg_chan_match #(.DW(DW), .NPORT(NPORT)) u_match (
    .hdr       (in_data),
    .iso       (in_iso),
    .port_en   ({p2_en, p1_en}),
    .port_chan ({p2_chan, p1_chan}),
    .accept    (accept_now)
  );

  rxg_wr_track #(.DW(DW), .AW(AW)) u_wr (
    .clk              (clk),
    .rst              (rst),
    .in_valid         (in_valid),
    .in_sop           (in_sop),
    .in_eop           (in_eop),
    .in_bad           (in_bad),
    .in_data          (in_data),
    .accept_now       (accept_now),
    .fifo_full        (fifo_full),
    .flush_bad        (flush_bad),
    .beat_wr          (beat_wr),
    .pkt_end          (pkt_end),
    .end_ok           (end_ok),
    .fifo_we          (fifo_we),
    .fifo_waddr       (fifo_waddr),
    .fifo_wdata       (fifo_wdata),
    .fifo_rewind      (fifo_rewind),
    .fifo_rewind_addr (fifo_rewind_addr),
    .rx_int           (rx_int)
  );

  rxg_block_split #(.TSW(TSW)) u_split (
    .clk       (clk),
    .rst       (rst),
    .trig_en   (trig_en),
    .trig_size (trig_size),
    .flush_bad (flush_bad),
    .beat_wr   (beat_wr),
    .pkt_end   (pkt_end),
    .end_ok    (end_ok),
    .blk_ready (blk_ready)
  );
endmodule

// File: rtl/rxg_checker.sv
module rxg_checker #(
  parameter int AW  = 9,
  parameter int TSW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           trig_en,
  input logic [TSW-1:0] trig_size,
  input logic           flush_bad,
  input logic           fifo_full,
  input logic           fifo_we,
  input logic [AW-1:0]  fifo_waddr,
  input logic           fifo_rewind,
  input logic           blk_ready,
  input logic           rx_int
);
  AST_WE_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> !$past(fifo_full)); // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (fifo_we && $past(fifo_we)) |-> (fifo_waddr == $past(fifo_waddr) + AW'(1))); // R4

  AST_REWIND_NO_INT: assert property (@(posedge clk) disable iff (rst)
    fifo_rewind |-> !rx_int); // R8

  AST_REWIND_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    fifo_rewind |-> !fifo_we); // R8

  AST_BLK_NEEDS_SIZE: assert property (@(posedge clk) disable iff (rst)
    blk_ready |-> ($past(trig_en) && ($past(trig_size) != '0))); // R7

  AST_FLUSH_NO_BLK: assert property (@(posedge clk) disable iff (rst)
    blk_ready |-> !$past(flush_bad)); // R10
endmodule

bind rx_iso_gate rxg_checker #(.AW(AW), .TSW(TSW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .trig_en     (trig_en),
  .trig_size   (trig_size),
  .flush_bad   (flush_bad),
  .fifo_full   (fifo_full),
  .fifo_we     (fifo_we),
  .fifo_waddr  (fifo_waddr),
  .fifo_rewind (fifo_rewind),
  .blk_ready   (blk_ready),
  .rx_int      (rx_int)
);

// File: tb/rx_iso_gate_bench.sv
module rx_iso_gate_bench;
  localparam int DW  = 32;
  localparam int AW  = 6;
  localparam int TSW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           p1_en = 1'b0, p2_en = 1'b0;
  logic [5:0]     p1_chan = '0, p2_chan = '0;
  logic           trig_en = 1'b0;
  logic [TSW-1:0] trig_size = '0;
  logic           flush_bad = 1'b0;
  logic           in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic           in_iso = 1'b0, in_bad = 1'b0, fifo_full = 1'b0;
  logic [DW-1:0]  in_data = '0;
  logic           fifo_we, fifo_rewind, blk_ready, rx_int;
  logic [AW-1:0]  fifo_waddr, fifo_rewind_addr;
  logic [DW-1:0]  fifo_wdata;

  always #4 clk = ~clk;

  rx_iso_gate #(.DW(DW), .AW(AW), .TSW(TSW)) u_rx_iso_gate (
    .clk(clk), .rst(rst), .p1_en(p1_en), .p1_chan(p1_chan), .p2_en(p2_en),
    .p2_chan(p2_chan), .trig_en(trig_en), .trig_size(trig_size),
    .flush_bad(flush_bad), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_iso(in_iso), .in_bad(in_bad), .in_data(in_data),
    .fifo_full(fifo_full), .fifo_we(fifo_we), .fifo_waddr(fifo_waddr),
    .fifo_wdata(fifo_wdata), .fifo_rewind(fifo_rewind),
    .fifo_rewind_addr(fifo_rewind_addr), .blk_ready(blk_ready), .rx_int(rx_int)
  );

  int n_chk = 0, n_fail = 0;
  int exp_ptr = 0;
  int n_we, n_blk, n_int, n_rew, first_addr, last_addr, rew_addr, late;
  logic [63:0] blk_mask;
  logic [DW-1:0] last_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic beat(input logic sop, input logic eop, input logic iso,
                      input logic bad, input logic full,
                      input logic [DW-1:0] d, input int idx);
    in_valid = 1'b1; in_sop = sop; in_eop = eop; in_iso = iso;
    in_bad = bad; fifo_full = full; in_data = d;
    @(posedge clk); #1;
    if (fifo_we) begin
      n_we++;
      if (n_we == 1) first_addr = int'(fifo_waddr);
      last_addr = int'(fifo_waddr);
      last_data = fifo_wdata;
    end
    if (blk_ready) begin
      n_blk++;
      if (idx < 64) blk_mask[idx] = 1'b1;
    end
    if (rx_int) n_int++;
    if (fifo_rewind) begin
      n_rew++;
      rew_addr = int'(fifo_rewind_addr);
    end
  endtask

  task automatic send_pkt(input logic iso, input logic [5:0] chan, input int n,
                          input logic bad, input int full_at);
    n_we = 0; n_blk = 0; n_int = 0; n_rew = 0; blk_mask = '0;
    first_addr = -1; last_addr = -1; rew_addr = -1; last_data = '0;
    for (int i = 0; i < n; i++) begin
      beat(i == 0, i == n - 1, iso, bad && (i == n - 1),
           (full_at >= 0) && (i >= full_at),
           (i == 0) ? {16'hA5A5, 2'b00, chan, 8'h11} : {8'hD0, 24'(i)}, i);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_bad = 1'b0; fifo_full = 1'b0;
    @(posedge clk); #1;
    late = int'(fifo_we) + int'(blk_ready) + int'(rx_int) + int'(fifo_rewind);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(!fifo_we && !fifo_rewind && !blk_ready && !rx_int, "R12", "outputs in reset",
        int'(fifo_we) + int'(fifo_rewind) + int'(blk_ready) + int'(rx_int), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(fifo_waddr == '0 && fifo_wdata == '0 && !rx_int, "R12", "outputs after reset",
        int'(fifo_waddr), 0);
  endtask

  task automatic t_port1();
    p1_en = 1'b1; p1_chan = 6'd5;
    send_pkt(1'b1, 6'd5, 4, 1'b0, -1);
    chk(n_we == 4, "R1", "port1 writes", n_we, 4);
    chk(first_addr == exp_ptr && last_addr == (exp_ptr + 3) % 64, "R4", "port1 last addr",
        last_addr, (exp_ptr + 3) % 64);
    chk(last_data == {8'hD0, 24'd3}, "R4", "port1 last data", last_data, {8'hD0, 24'd3});
    chk(n_int == 1 && late == 0, "R11", "port1 interrupt", n_int, 1);
    exp_ptr = (exp_ptr + 4) % 64;
  endtask

  task automatic t_port2();
    p2_en = 1'b1; p2_chan = 6'd33;
    send_pkt(1'b1, 6'd33, 3, 1'b0, -1);
    chk(n_we == 3 && first_addr == exp_ptr, "R2", "port2 writes", n_we, 3);
    exp_ptr = (exp_ptr + 3) % 64;
    p1_en = 1'b0;
    send_pkt(1'b1, 6'd33, 2, 1'b0, -1);
    chk(n_we == 2 && n_int == 1, "R2", "port2 alone", n_we, 2);
    exp_ptr = (exp_ptr + 2) % 64;
  endtask

  task automatic t_reject();
    send_pkt(1'b1, 6'd5, 3, 1'b0, -1);
    chk(n_we == 0 && n_int == 0, "R3", "disabled port1 rejects", n_we + n_int, 0);
    send_pkt(1'b1, 6'd7, 3, 1'b0, -1);
    chk(n_we == 0 && n_int == 0, "R3", "unmatched channel rejects", n_we + n_int, 0);
    send_pkt(1'b0, 6'd7, 2, 1'b0, -1);
    chk(n_we == 2 && first_addr == exp_ptr, "R3", "non-iso accepted", n_we, 2);
    exp_ptr = (exp_ptr + 2) % 64;
    p1_en = 1'b1;
  endtask

  task automatic t_wrap();
    send_pkt(1'b1, 6'd5, 70, 1'b0, -1);
    chk(n_we == 70 && last_addr == (exp_ptr + 69) % 64, "R4", "address wrap",
        last_addr, (exp_ptr + 69) % 64);
    exp_ptr = (exp_ptr + 70) % 64;
  endtask

  task automatic t_trig();
    trig_en = 1'b1; trig_size = 8'd4;
    send_pkt(1'b1, 6'd5, 10, 1'b0, -1);
    chk(blk_mask == 64'h288, "R5", "blocks at 3,7 and tail 9", blk_mask, 64'h288);
    exp_ptr = (exp_ptr + 10) % 64;
    send_pkt(1'b1, 6'd5, 8, 1'b0, -1);
    chk(blk_mask == 64'h88 && n_blk == 2, "R6", "exact multiple no extra", blk_mask, 64'h88);
    exp_ptr = (exp_ptr + 8) % 64;
    send_pkt(1'b1, 6'd5, 3, 1'b0, -1);
    chk(blk_mask == 64'h4, "R6", "short packet tail", blk_mask, 64'h4);
    exp_ptr = (exp_ptr + 3) % 64;
    trig_size = 8'd0;
    send_pkt(1'b1, 6'd5, 6, 1'b0, -1);
    chk(n_blk == 0 && n_we == 6, "R7", "zero size disables", n_blk, 0);
    exp_ptr = (exp_ptr + 6) % 64;
    trig_size = 8'd2;
  endtask

  task automatic t_flush();
    int start;
    flush_bad = 1'b1;
    send_pkt(1'b1, 6'd5, 6, 1'b0, -1);
    chk(n_blk == 0 && n_int == 1, "R10", "flush overrides trigger", n_blk, 0);
    exp_ptr = (exp_ptr + 6) % 64;
    trig_en = 1'b0;
    start = exp_ptr;
    send_pkt(1'b1, 6'd5, 5, 1'b1, -1);
    chk(n_we == 4, "R8", "flushed packet writes", n_we, 4);
    chk(n_rew == 1 && rew_addr == start, "R8", "rewind address", rew_addr, start);
    chk(n_int == 0, "R8", "no interrupt on flush", n_int, 0);
    send_pkt(1'b1, 6'd5, 2, 1'b0, -1);
    chk(first_addr == start, "R8", "next packet reuses start", first_addr, start);
    exp_ptr = (exp_ptr + 2) % 64;
    start = exp_ptr;
    send_pkt(1'b1, 6'd5, 5, 1'b0, 2);
    chk(n_we == 2 && n_rew == 1 && rew_addr == start && n_int == 0, "R9",
        "truncated packet flushed", n_we, 2);
    flush_bad = 1'b0;
    send_pkt(1'b1, 6'd5, 3, 1'b1, -1);
    chk(n_int == 1 && n_rew == 0 && n_we == 3, "R11", "bad kept without flush", n_int, 1);
    exp_ptr = (exp_ptr + 3) % 64;
    send_pkt(1'b1, 6'd5, 5, 1'b0, 2);
    chk(n_we == 2 && n_int == 1 && n_rew == 0, "R9", "truncation without flush", n_we, 2);
    exp_ptr = (exp_ptr + 2) % 64;
    send_pkt(1'b1, 6'd5, 1, 1'b0, -1);
    chk(first_addr == exp_ptr, "R9", "pointer after truncation", first_addr, exp_ptr);
  endtask

  initial begin
    t_reset();
    t_port1();
    t_port2();
    t_reject();
    t_wrap();
    t_trig();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule